// File: doc/BRIEF.md
# Single/Double Click Discriminator

This block is a clocked reactive controller that sorts pointer-button clicks into single and double clicks. A separate strobe supplies the time base: the block measures its decision window in strobe occurrences, not in clock cycles. After an arm pulse, the controller waits for a first click. That click opens a window five strobes long. Inside the window, the controller watches for a second click and counts strobes at the same time.

A second click inside the window produces a double report. If the fifth strobe passes with no second click, a single report comes instead. Each window produces exactly one report, and the report appears as a registered one-cycle pulse. Once the decision is made, the controller goes straight back to waiting for a new first click. Every wait in the block ignores events in the cycle in which that wait begins.

Top module: `click_discriminator`

## Requirements
- R1: A synchronous active-high reset returns the controller to the unarmed state, clears the strobe count and drives both report outputs low in the cycle after reset is sampled.
- R2: While the controller is unarmed, clicks and strobes produce no report.
- R3: An arm pulse moves the unarmed controller to waiting for a first click. A click in the same cycle as the arm pulse is ignored.
- R4: A click while waiting opens the window. A strobe in that same cycle is not counted, and that click never counts as the second click.
- R5: A click in any later cycle of an open window ends the window. `double_o` is high for the cycle after that click is sampled.
- R6: If the fifth counted strobe of a window arrives with no click in that cycle, the window ends and `single_o` is high for the cycle after.
- R7: A click in the same cycle as the fifth strobe yields only a double report.
- R8: Each report is a single-cycle pulse, and `single_o` and `double_o` are never high together.
- R9: The controller re-arms in the cycle that ends a window. A click in that cycle is ignored, and a click in the next cycle opens a new window.
- R10: Only cycles with the strobe high advance the count. Cycles without the strobe leave the window open and uncounted.
- R11: An arm pulse while the controller is already armed has no effect on waiting or on an open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm pulse, leaves the unarmed state |
| click_i | input | 1 | Click event pulse |
| tick_i | input | 1 | Time-base strobe |
| single_o | output | 1 | One-cycle single-click report |
| double_o | output | 1 | One-cycle double-click report |

## Verification
The hardest case to reach from the ports is a second click that falls in exactly the same cycle as the fifth counted strobe. To get there, the stimulus has to open a window, deliver four strobes with gaps that do not advance the count, and then raise the click and the strobe together. The stimulus also places events at the edges of each wait: a click together with the arm pulse, a strobe together with the first click, and a click in the cycle a window closes. These show that none of them leaks into the count or the classification. A reset applied mid-window, followed by clicks, confirms that the controller returns to the unarmed state.

// File: rtl/click_disc_pkg.sv
package click_disc_pkg;

    localparam int unsigned DEF_WINDOW_TICKS = 5;

    typedef enum logic [1:0] {
        ST_UNARMED = 2'd0,
        ST_WAIT    = 2'd1,
        ST_WINDOW  = 2'd2
    } cd_state_e;

    typedef struct packed {
        logic single_hit;
        logic double_hit;
    } cd_verdict_t;

    function automatic cd_verdict_t judge(input logic in_window,
                                          input logic click,
                                          input logic timeout);
        cd_verdict_t v;
        v.double_hit = in_window & click;
        v.single_hit = in_window & timeout & ~click;
        return v;
    endfunction

endpackage

// File: rtl/cd_tick_counter.sv
module cd_tick_counter #(
    parameter int unsigned WINDOW_TICKS = 5,
    localparam int unsigned CNT_W = $clog2(WINDOW_TICKS + 1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic step_i,
    output logic timeout_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign timeout_o = step_i && (count_q == LAST);
endmodule

// File: rtl/cd_ctrl.sv
module cd_ctrl
    import click_disc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        arm_i,
    input  logic        click_i,
    input  logic        timeout_i,
    output logic        in_window_o,
    output cd_verdict_t verdict_o,
    output cd_state_e   state_o
);
    cd_state_e   state_q, state_d;
    cd_verdict_t verdict;

    assign in_window_o = (state_q == ST_WINDOW);
    assign verdict     = judge(in_window_o, click_i, timeout_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNARMED: if (arm_i)   state_d = ST_WAIT;
            ST_WAIT:    if (click_i) state_d = ST_WINDOW;
            ST_WINDOW:  if (verdict.single_hit || verdict.double_hit)
                            state_d = ST_WAIT;
            default:    state_d = ST_UNARMED;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_UNARMED;
        else       state_q <= state_d;
    end

    assign verdict_o = verdict;
    assign state_o   = state_q;
endmodule

// File: rtl/cd_pulse_reg.sv
module cd_pulse_reg
    import click_disc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  cd_verdict_t verdict_i,
    output logic        single_o,
    output logic        double_o
);
    cd_verdict_t out_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) out_q <= '0;
        else       out_q <= verdict_i;
    end

    assign single_o = out_q.single_hit;
    assign double_o = out_q.double_hit;
endmodule

// File: rtl/click_discriminator.sv
module click_discriminator
    import click_disc_pkg::*;
#(
    parameter int unsigned WINDOW_TICKS = DEF_WINDOW_TICKS
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_i,
    input  logic click_i,
    input  logic tick_i,
    output logic single_o,
    output logic double_o
);
    logic        in_window;
    logic        timeout;
    cd_verdict_t verdict;
    cd_state_e   ctrl_state;

    cd_tick_counter #(.WINDOW_TICKS(WINDOW_TICKS)) u_count (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clear_i  (~in_window),
        .step_i   (in_window & tick_i),
        .timeout_o(timeout)
    );

    cd_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .arm_i      (arm_i),
        .click_i    (click_i),
        .timeout_i  (timeout),
        .in_window_o(in_window),
        .verdict_o  (verdict),
        .state_o    (ctrl_state)
    );

    cd_pulse_reg u_out (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .verdict_i(verdict),
        .single_o (single_o),
        .double_o (double_o)
    );
endmodule

// File: rtl/click_disc_checker.sv
module click_disc_checker
    import click_disc_pkg::*;
(
    input logic      clk_i,
    input logic      rst_i,
    input logic      click_i,
    input logic      tick_i,
    input logic      single_o,
    input logic      double_o,
    input cd_state_e ctrl_state
);
    AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(single_o && double_o)); // R8

    AST_SINGLE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        single_o |=> !single_o); // R8

    AST_DOUBLE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        double_o |=> !double_o); // R8

    AST_UNARMED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_state == ST_UNARMED) |=> (!single_o && !double_o)); // R2

    AST_DOUBLE_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        double_o |-> $past(click_i)); // R5

    AST_SINGLE_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        single_o |-> ($past(tick_i) && !$past(click_i))); // R7

    AST_REARMED: assert property (@(posedge clk_i) disable iff (rst_i)
        (single_o || double_o) |-> (ctrl_state == ST_WAIT)); // R9
endmodule

bind click_discriminator click_disc_checker u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .click_i   (click_i),
    .tick_i    (tick_i),
    .single_o  (single_o),
    .double_o  (double_o),
    .ctrl_state(ctrl_state)
);

// File: tb/click_discriminator_bench.sv
module click_discriminator_bench;
    logic clk = 1'b0;
    logic rst, arm, click, tick;
    logic single_o, double_o;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    click_discriminator u_click_discriminator (
        .clk_i(clk), .rst_i(rst), .arm_i(arm), .click_i(click), .tick_i(tick),
        .single_o(single_o), .double_o(double_o)
    );

    // {req[3:0], arm, click, tick, exp_single, exp_double}
    localparam int NV = 26;
    localparam logic [8:0] VEC [NV] = '{
        {4'd2,  5'b01100}, // R2 unarmed: click+tick ignored
        {4'd3,  5'b11000}, // R3 arm, same-cycle click ignored
        {4'd10, 5'b00100}, // R10 tick while waiting not counted
        {4'd4,  5'b01000}, // R4 first click opens window
        {4'd10, 5'b00100}, // R10 tick 1
        {4'd10, 5'b00000}, // R10 gap
        {4'd10, 5'b00100}, // tick 2
        {4'd10, 5'b00100}, // tick 3
        {4'd10, 5'b00100}, // tick 4
        {4'd10, 5'b00000}, // gap
        {4'd6,  5'b00110}, // R6 fifth tick -> single
        {4'd9,  5'b01000}, // R9 click right after opens window
        {4'd5,  5'b01001}, // R5 second click -> double
        {4'd9,  5'b01000}, // R9 next-cycle click opens new window
        {4'd10, 5'b00100}, // tick 1
        {4'd10, 5'b00100}, // tick 2
        {4'd10, 5'b00100}, // tick 3
        {4'd10, 5'b00100}, // tick 4
        {4'd7,  5'b01101}, // R7 click with fifth tick -> double only
        {4'd4,  5'b01100}, // R4 tick with first click not counted
        {4'd4,  5'b00100}, // tick 1
        {4'd4,  5'b00100}, // tick 2
        {4'd4,  5'b00100}, // tick 3
        {4'd4,  5'b00100}, // tick 4
        {4'd11, 5'b10110}, // R11 arm ignored, fifth tick -> single
        {4'd8,  5'b00000}  // R8 pulse lasted one cycle
    };

    task automatic step(input logic a, input logic c, input logic t);
        @(negedge clk);
        arm = a; click = c; tick = t;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic es, input logic ed);
        n_run++;
        if (single_o !== es || double_o !== ed) begin
            n_fail++;
            $display("FAIL %s: single/double = %b%b, expected %b%b",
                     req, single_o, double_o, es, ed);
        end
    endtask

    initial begin
        rst = 1'b1; arm = 1'b0; click = 1'b0; tick = 1'b0;
        step(0, 0, 0);
        step(0, 0, 0);
        check("R1", 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][4], VEC[i][3], VEC[i][2]);
            check($sformatf("R%0d row %0d", VEC[i][8:5], i), VEC[i][1], VEC[i][0]);
        end

        // R1: reset in the middle of an open window
        step(0, 1, 0);
        step(0, 0, 1);
        step(0, 0, 1);
        @(negedge clk) rst = 1'b1;
        step(0, 0, 1);
        check("R1", 1'b0, 1'b0);
        @(negedge clk) rst = 1'b0;
        step(0, 1, 1);
        step(0, 1, 1);
        step(0, 0, 1);
        check("R1", 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            step(0, (k % 2) == 0, 1'b1);
            check("R2", 1'b0, 1'b0);
        end
        // R3: re-arm after reset, then a double
        step(1, 0, 0);
        step(0, 1, 0);
        check("R3", 1'b0, 1'b0);
        step(0, 1, 0);
        check("R5", 1'b0, 1'b1);
        step(0, 0, 0);
        check("R8", 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule